// File: doc/BRIEF.md
# Triangular-Weighted Sample Smoothing Filter

This block smooths a stream of signed 14-bit sensor samples with a triangular (Bartlett) weighted FIR filter. The filter is formed by running each accepted sample through two identical moving-average stages of length N = 2^M. The frequency response of the cascade is the square of one moving-average response, and its impulse response is a triangle that spans 2N−1 taps. The exponent M comes from a 3-bit configuration input, so N can be any power of two from 1 to 128. Because N is a power of two, the final normalisation by N² is an arithmetic shift and needs no divider.

The filter accepts one sample on every cycle in which the sample strobe is high, and it returns exactly one filtered sample for each accepted input. The idle cycles between strobes set the internal sample rate. Changing the exponent flushes all history, so a new setting starts from a clean state. A settled flag marks the outputs whose whole triangular window lies inside the samples taken since that flush.

Top module: `bartlett_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, outValid and outSettled are 0 and outData is 0.
- R2: Each sample accepted at a clock edge produces exactly one outValid pulse two clock edges later. No output appears in any other cycle, and idle gaps between strobes are allowed.
- R3: The output for accepted sample k equals floor( Σ w_j·x[k−j] / N² ) for j = 0..2N−2, with w_j = j+1 for j < N and w_j = 2N−1−j otherwise. Samples from before the last flush count as 0.
- R4: N = 2^M for every M in 0..7, where M is mSel read as unsigned. With M = 0 the output equals the input sample.
- R5: The division by N² rounds toward negative infinity. For example, an impulse of −1 with M = 3 produces −1 at every tap where the weight is nonzero.
- R6: No intermediate sum overflows. A constant full-scale input of +8191 or −8192 with M = 7 settles to exactly that value.
- R7: A change of mSel clears all history, so the first output after the change uses only samples accepted under the new setting.
- R8: outSettled is 1 together with outValid exactly when the sample index since the last flush (counting from 0) is at least 2·(N−1). Otherwise it is 0.
- R9: A sample presented in the cycle where mSel changes is discarded. Any sample still in the pipeline at that edge produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | Sample strobe; high for one cycle per sample |
| sampleData | input | 14 | Signed two's-complement sample |
| mSel | input | 3 | Exponent M of the stage length N = 2^M |
| outValid | output | 1 | Filtered sample is valid |
| outData | output | 14 | Signed filtered sample |
| outSettled | output | 1 | Filtered sample uses a fully populated window |

## Verification
A wrong history pointer or a stale history entry shows up as an output value that leaves the triangular reference. With an impulse stimulus this is visible within 2N−1 outputs of the fault, and with full-scale constant input it shows as a plateau at the wrong level. A flush that is missed or incomplete shows on the first outputs after an exponent change, which then carry energy from the earlier setting. A miscounted settle counter makes the settled flag rise one or more samples early or late. Lost or duplicated output strobes are caught on the very next result, because results are matched in order against expected items queued at input time.

// File: rtl/bartlett_pkg.sv
package bartlett_pkg;
  localparam int DATA_W = 14;
  localparam int MAX_M  = 7;
  localparam int M_W    = $clog2(MAX_M + 1);
  localparam int STAGES = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic           clear;
    logic           accept;
    logic [M_W-1:0] m;
  } ctrlT;
endpackage

// File: rtl/boxcar_stage.sv
module boxcar_stage #(
  parameter int IN_W  = 14,
  parameter int MAX_M = 7,
  parameter int M_W   = 3,
  localparam int SUM_W = IN_W + MAX_M
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  input  logic [M_W-1:0]          m,
  output logic                    outValid,
  output logic signed [SUM_W-1:0] sumOut
);
  localparam int DEPTH = 1 << MAX_M;
  localparam int PTR_W = MAX_M;

  logic signed [IN_W-1:0] hist [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic signed [SUM_W-1:0] runSum;
  logic signed [SUM_W-1:0] sumNext;

  // the entry N positions back; for N = DEPTH the shift wraps to zero
  always_comb begin
    rdPtr   = wrPtr - (PTR_W'(1) << m);
    sumNext = runSum + SUM_W'(inData) - SUM_W'(hist[rdPtr]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      wrPtr    <= '0;
      runSum   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        hist[wrPtr] <= inData;
        wrPtr       <= wrPtr + PTR_W'(1);
        runSum      <= sumNext;
      end
    end
  end

  assign sumOut = runSum;
endmodule

// File: rtl/bartlett_ctrl.sv
module bartlett_ctrl
  import bartlett_pkg::*;
#(
  parameter int MAX_M_P  = MAX_M,
  parameter int STAGES_P = STAGES
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleValid,
  input  logic [M_W-1:0] mSel,
  output ctrlT           ctrl,
  output logic           outSettled
);
  localparam int CNT_W = MAX_M_P + 2;

  logic [M_W-1:0]      mCur;
  logic                changeReq;
  logic [CNT_W-1:0]    acceptCnt;
  logic [CNT_W-1:0]    settleLim;
  logic                settledNow;
  logic [STAGES_P-1:0] settlePipe;

  always_comb begin
    changeReq   = (mSel != mCur);
    ctrl.clear  = changeReq;
    ctrl.accept = sampleValid & ~changeReq;
    ctrl.m      = mCur;
    settleLim   = ((CNT_W'(1) << mCur) - CNT_W'(1)) << 1;
    settledNow  = (acceptCnt >= settleLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mCur       <= '0;
      acceptCnt  <= '0;
      settlePipe <= '0;
    end else if (changeReq) begin
      mCur       <= mSel;
      acceptCnt  <= '0;
      settlePipe <= '0;
    end else begin
      settlePipe <= (settlePipe << 1) | STAGES_P'(ctrl.accept & settledNow);
      if (ctrl.accept && (acceptCnt != '1)) acceptCnt <= acceptCnt + CNT_W'(1);
    end
  end

  assign outSettled = settlePipe[STAGES_P-1];
endmodule

// File: rtl/bartlett_datapath.sv
module bartlett_datapath
  import bartlett_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int MAX_M_P  = MAX_M,
  parameter int STAGES_P = STAGES
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlT                       ctrl,
  input  logic signed [DATA_W_P-1:0] sampleData,
  output logic                       outValid,
  output logic signed [DATA_W_P-1:0] outData
);
  localparam int FIN_W = DATA_W_P + STAGES_P * MAX_M_P;
  localparam int SH_W  = $clog2(STAGES_P * MAX_M_P + 1);

  for (genvar g = 0; g < STAGES_P; g++) begin : stg
    localparam int IN_W = DATA_W_P + g * MAX_M_P;
    logic signed [IN_W-1:0]         stageIn;
    logic                           stageInValid;
    logic signed [IN_W+MAX_M_P-1:0] sumOut;
    logic                           sumValid;

    if (g == 0) begin : gHead
      assign stageIn      = sampleData;
      assign stageInValid = ctrl.accept;
    end else begin : gChain
      assign stageIn      = stg[g-1].sumOut;
      assign stageInValid = stg[g-1].sumValid;
    end

    boxcar_stage #(
      .IN_W (IN_W),
      .MAX_M(MAX_M_P),
      .M_W  (M_W)
    ) u_stage (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (ctrl.clear),
      .inValid (stageInValid),
      .inData  (stageIn),
      .m       (ctrl.m),
      .outValid(sumValid),
      .sumOut  (sumOut)
    );
  end

  logic signed [FIN_W-1:0] finSum;
  logic [SH_W-1:0]         shAmt;
  logic signed [FIN_W-1:0] scaled;

  always_comb begin
    finSum   = stg[STAGES_P-1].sumOut;
    shAmt    = SH_W'(ctrl.m * STAGES_P);
    scaled   = finSum >>> shAmt;
    outData  = DATA_W_P'(scaled);
    outValid = stg[STAGES_P-1].sumValid;
  end
endmodule

// File: rtl/bartlett_filter.sv
module bartlett_filter
  import bartlett_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleData,
  input  logic [M_W-1:0]           mSel,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData,
  output logic                     outSettled
);
  ctrlT ctrl;

  bartlett_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .mSel       (mSel),
    .ctrl       (ctrl),
    .outSettled (outSettled)
  );

  bartlett_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .sampleData(sampleData),
    .outValid  (outValid),
    .outData   (outData)
  );
endmodule

// File: rtl/bartlett_filter_chk.sv
module bartlett_filter_chk
  import bartlett_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic signed [DATA_W-1:0] sampleData,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outData,
  input logic                     outSettled,
  input logic [M_W-1:0]           activeM,
  input logic                     clearStb
);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid, 2));

  // R8
  settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSettled |-> outValid);

  // R4
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && activeM == '0 && $past(activeM) == '0) |-> outData == $past(sampleData, 2));

  // R9
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearStb) |-> !outValid);

  // R9
  clear_flush2_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearStb, 2) |-> !outValid);
endmodule

bind bartlett_filter bartlett_filter_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .sampleData (sampleData),
  .outValid   (outValid),
  .outData    (outData),
  .outSettled (outSettled),
  .activeM    (ctrl.m),
  .clearStb   (ctrl.clear)
);

// File: tb/bartlett_filter_tb.sv
module bartlett_filter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [13:0] sampleData = '0;
  logic [2:0] mSel = '0;
  logic outValid;
  logic signed [13:0] outData;
  logic outSettled;

  int checks = 0;
  int errors = 0;
  int strays = 0;
  int curM = 0;
  bit lastValid = 0;

  typedef struct {
    logic signed [13:0] data;
    bit                 settled;
    string              tag;
  } expT;

  expT expQ[$];
  longint histQ[$];

  always #5 clk = ~clk;

  bartlett_filter u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .mSel(mSel), .outValid(outValid), .outData(outData), .outSettled(outSettled)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // driver: one cycle of stimulus, queues the expected result
  task automatic drive(bit v, logic signed [13:0] x, string tag);
    expT e;
    longint acc;
    longint w;
    int n;
    @(posedge clk); #1;
    sampleValid = v;
    sampleData  = x;
    lastValid   = v;
    if (v) begin
      n = 1 << curM;
      e.settled = (histQ.size() >= 2 * n - 2);
      histQ.push_front(longint'(x));
      if (histQ.size() > 256) void'(histQ.pop_back());
      acc = 0;
      for (int j = 0; j < 2 * n - 1 && j < histQ.size(); j++) begin
        w = (j < n) ? j + 1 : 2 * n - 1 - j;
        acc += w * histQ[j];
      end
      e.data = 14'(acc >>> (2 * curM));
      e.tag  = tag;
      expQ.push_back(e);
    end
  endtask

  // exponent change, optionally with a sample in the same cycle (R9)
  task automatic setM(int newM, bit withSample);
    @(posedge clk); #1;
    if (lastValid && expQ.size() > 0) void'(expQ.pop_back());
    mSel        = 3'(newM);
    sampleValid = withSample;
    sampleData  = 14'sd1234;
    lastValid   = 0;
    curM        = newM;
    histQ.delete();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, "");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        strays++;
        errors++;
        checks++;
        $display("FAIL R2/R9 unexpected output: actual=%0d expected=none", outData);
      end else begin
        expT e;
        e = expQ.pop_front();
        checks++;
        if (outData !== e.data || outSettled !== e.settled) begin
          errors++;
          $display("FAIL %s: actual data=%0d settled=%0b expected data=%0d settled=%0b",
                   e.tag, outData, outSettled, e.data, e.settled);
        end
      end
    end
  end

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (outValid !== 1'b0 || outData !== '0 || outSettled !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual v=%0b d=%0d s=%0b expected 0 0 0", outValid, outData, outSettled);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      errors++;
      $display("FAIL R1 after reset: actual v=%0b d=%0d expected 0 0", outValid, outData);
    end

    // R4 passthrough with M = 0
    for (int i = 0; i < 20; i++) drive(1, 14'($urandom), "R4");
    idle(3);

    // R3 impulse response, M = 3
    setM(3, 0);
    drive(1, 14'sd4000, "R3");
    for (int i = 0; i < 20; i++) drive(1, '0, "R3");
    // R5 negative unit impulse floors to -1 on every nonzero tap
    drive(1, -14'sd1, "R5");
    for (int i = 0; i < 18; i++) drive(1, '0, "R5");
    drive(1, 14'sd1, "R5");
    for (int i = 0; i < 18; i++) drive(1, '0, "R5");
    idle(3);

    // R6 full scale with the longest window
    setM(7, 0);
    for (int i = 0; i < 300; i++) drive(1, 14'sd8191, "R6");
    for (int i = 0; i < 300; i++) drive(1, -14'sd8192, "R6");
    idle(3);

    // R3 / R8 random data with idle gaps, M = 2
    setM(2, 0);
    for (int i = 0; i < 60; i++) begin
      drive(1, 14'($urandom), "R8");
      if (i % 3 == 1) idle(1 + (i % 4));
    end
    // R9 change with a sample in flight and one in the change cycle
    setM(5, 1);
    // R7 fresh history under new exponent
    for (int i = 0; i < 80; i++) drive(1, 14'($urandom), "R7");
    idle(2);
    setM(1, 0);
    for (int i = 0; i < 10; i++) drive(1, 14'($urandom), "R7");
    for (int m = 4; m <= 6; m++) begin
      setM(m, 0);
      for (int i = 0; i < 140; i++) drive(1, 14'($urandom), "R3");
      idle(1);
    end
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 missing outputs: actual=%0d pending expected=0", expQ.size());
    end
    checks++;
    if (strays != 0) begin
      $display("FAIL R9 stray outputs: actual=%0d expected=0", strays);
    end
    summary();
    $finish;
  end
endmodule